// File: doc/BRIEF.md
# Cascaded Secondary Interrupt Controller

This block gathers 32 level-sensitive interrupt sources in front of a primary interrupt controller. It keeps one level bit per source. Software can also set and clear these bits through the register bus. An enable mask selects which sources take part in a single combined request. That request is driven on one nominated primary line, the cascade line.

Sources 21 to 30 can each be put in pass-through. A source in pass-through drives the primary line with the same number straight from its level bit, and the mask has no effect on it. The combined cascade request keeps working alongside this.

Registers sit in a 4 KB window and are reached by a 10-bit word index, which is byte-address bits [11:2]. Reads are combinational. Writes take effect at the next clock edge.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it is released, the level, mask and pass-through registers are zero, every `irq_out` line is low, and every register reads as zero.
- R2: When an `irq_in` bit differs from its value at the previous clock edge, the level bit takes the new input value at the next edge. In that cycle this update wins over any software set or clear of the same bit.
- R3: A write to word 4 sets the level bits where `bus_wdata` is 1. A write to word 5 clears the level bits where `bus_wdata` is 1. Word 1 reads the raw level register.
- R4: A write to word 2 sets the mask bits where `bus_wdata` is 1. A write to word 3 clears them where `bus_wdata` is 1. Word 2 reads the mask.
- R5: Word 0 reads the level register ANDed with the mask.
- R6: `irq_out[CASC_LINE]` (default 31) is high exactly when (level & mask) is non-zero. It follows the registers with no added clock stage.
- R7: A write to word 8 sets pass-through enable bits from `bus_wdata & 0x7FE00000`, so only bits 21 to 30 can be set. A write to word 9 clears the enable bits where `bus_wdata` is 1. Word 8 reads the enable register.
- R8: For each line i from 21 to 30 that is not the cascade line, `irq_out[i]` equals level bit i when its pass-through enable is set, whatever the mask, and is low when the enable is clear. All other lines except the cascade line stay low.
- R9: Word indices other than 0, 1, 2 and 8 read as zero. Writes to indices other than 2, 3, 4, 5, 8 and 9 change no register. `bus_rdata` is zero whenever no read is selected (`bus_sel` low or `bus_wr` high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 32 | Level-sensitive interrupt sources |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_word | input | 10 | Word index, byte-address bits [11:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_out | output | 32 | Lines toward the primary controller |

## Verification
The bound checker watches these properties on every cycle:
- the mask set and clear writes;
- software setting level bits;
- level bits following input changes;
- pass-through enables never leaving bits 21 to 30;
- writes to undefined words leaving the mask and enables untouched.

Other behaviour only the bench's scenarios can show, through its cycle-level reference model:
- the cascade request and pass-through lines matching the model;
- input changes winning over a clear written in the same cycle;
- the read values of every word index.

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl #(
  parameter int LINES     = 32,
  parameter int CASC_LINE = 31,
  parameter int PT_LO     = 21,
  parameter int PT_HI     = 30,
  parameter int AW        = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [AW-1:2]     bus_word,
  input  logic [LINES-1:0]  bus_wdata,
  output logic [LINES-1:0]  bus_rdata,
  output logic [LINES-1:0]  irq_out
);
  localparam int IDXW = AW - 2;
  localparam logic [LINES-1:0] PT_MASK =
    ({LINES{1'b1}} << PT_LO) & ~({LINES{1'b1}} << (PT_HI + 1));
  localparam logic [IDXW-1:0] W_STAT = IDXW'(0), W_RAW  = IDXW'(1),
                              W_MSET = IDXW'(2), W_MCLR = IDXW'(3),
                              W_LSET = IDXW'(4), W_LCLR = IDXW'(5),
                              W_PSET = IDXW'(8), W_PCLR = IDXW'(9);

  logic [LINES-1:0] lvl_q, msk_q, pte_q, in_q, lvl_sw, chg;
  wire wr_hit = bus_sel & bus_wr;
  wire rd_hit = bus_sel & ~bus_wr;

  assign chg = irq_in ^ in_q;

  always_comb begin
    lvl_sw = lvl_q;
    if (wr_hit && bus_word == W_LSET) lvl_sw = lvl_q | bus_wdata;
    if (wr_hit && bus_word == W_LCLR) lvl_sw = lvl_q & ~bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      msk_q <= '0;
      pte_q <= '0;
      in_q  <= '0;
    end else begin
      in_q  <= irq_in;
      lvl_q <= (lvl_sw & ~chg) | (irq_in & chg);
      if (wr_hit && bus_word == W_MSET) msk_q <= msk_q | bus_wdata;
      if (wr_hit && bus_word == W_MCLR) msk_q <= msk_q & ~bus_wdata;
      if (wr_hit && bus_word == W_PSET) pte_q <= pte_q | (bus_wdata & PT_MASK);
      if (wr_hit && bus_word == W_PCLR) pte_q <= pte_q & ~bus_wdata;
    end
  end

  always_comb begin
    irq_out = lvl_q & pte_q;
    irq_out[CASC_LINE] = |(lvl_q & msk_q);
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_hit) begin
      case (bus_word)
        W_STAT:  bus_rdata = lvl_q & msk_q;
        W_RAW:   bus_rdata = lvl_q;
        W_MSET:  bus_rdata = msk_q;
        W_PSET:  bus_rdata = pte_q;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

module cascade_irq_ctrl_chk #(
  parameter int LINES = 32,
  parameter int PT_LO = 21,
  parameter int PT_HI = 30,
  parameter int AW    = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LINES-1:0] irq_in,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [AW-1:2]    bus_word,
  input logic [LINES-1:0] bus_wdata,
  input logic [LINES-1:0] lvl_q,
  input logic [LINES-1:0] msk_q,
  input logic [LINES-1:0] pte_q,
  input logic [LINES-1:0] in_q
);
  localparam logic [LINES-1:0] PT_MASK =
    ({LINES{1'b1}} << PT_LO) & ~({LINES{1'b1}} << (PT_HI + 1));
  wire wr = bus_sel & bus_wr;
  wire known = (bus_word == (AW-2)'(2)) || (bus_word == (AW-2)'(3)) ||
               (bus_word == (AW-2)'(4)) || (bus_word == (AW-2)'(5)) ||
               (bus_word == (AW-2)'(8)) || (bus_word == (AW-2)'(9));

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_word == (AW-2)'(2)) |=> ((msk_q & $past(bus_wdata)) == $past(bus_wdata))); // R4
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_word == (AW-2)'(3)) |=> ((msk_q & $past(bus_wdata)) == '0)); // R4
  AST_LVL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_word == (AW-2)'(4)) |=>
      ((lvl_q & $past(bus_wdata & ~(irq_in ^ in_q))) == $past(bus_wdata & ~(irq_in ^ in_q)))); // R3
  AST_LVL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_in != in_q) |=> (((lvl_q ^ $past(irq_in)) & $past(irq_in ^ in_q)) == '0)); // R2
  AST_PT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (pte_q & ~PT_MASK) == '0); // R7
  AST_UNDEF_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !known) |=> ($stable(msk_q) && $stable(pte_q))); // R9
endmodule

bind cascade_irq_ctrl cascade_irq_ctrl_chk #(
  .LINES(LINES), .PT_LO(PT_LO), .PT_HI(PT_HI), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel),
  .bus_wr(bus_wr), .bus_word(bus_word), .bus_wdata(bus_wdata),
  .lvl_q(lvl_q), .msk_q(msk_q), .pte_q(pte_q), .in_q(in_q)
);

// File: tb/test_cascade_irq_ctrl.sv
module test_cascade_irq_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] irq_in = '0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [11:2] bus_word = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, irq_out;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_level = '0, m_mask = '0, m_pt = '0, m_prev = '0;

  always #4 clk = ~clk;

  cascade_irq_ctrl i_cascade_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_word(bus_word), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_out();
    logic [31:0] e = '0;
    for (int k = 21; k <= 30; k++) if (m_pt[k]) e[k] = m_level[k];
    e[31] = (m_level & m_mask) != 0;
    return e;
  endfunction

  function automatic logic [31:0] exp_rd();
    if (!bus_sel || bus_wr) return '0;
    case (int'(bus_word))
      0: return m_level & m_mask;
      1: return m_level;
      2: return m_mask;
      8: return m_pt;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_level = '0; m_mask = '0; m_pt = '0; m_prev = '0;
    end else begin
      logic [31:0] nl;
      nl = m_level;
      if (bus_sel && bus_wr) begin
        case (int'(bus_word))
          2: m_mask = m_mask | bus_wdata;
          3: m_mask = m_mask & ~bus_wdata;
          4: nl = nl | bus_wdata;
          5: nl = nl & ~bus_wdata;
          8: m_pt = m_pt | (bus_wdata & 32'h7FE0_0000);
          9: m_pt = m_pt & ~bus_wdata;
          default: ;
        endcase
      end
      for (int k = 0; k < 32; k++) if (irq_in[k] != m_prev[k]) nl[k] = irq_in[k];
      m_level = nl;
      m_prev = irq_in;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 R8", irq_out, exp_out());
      chk("R5 R9", bus_rdata, exp_rd());
    end
  end

  task automatic drive(bit s, bit w, int word, logic [31:0] d);
    @(posedge clk); #2;
    bus_sel = s; bus_wr = w; bus_word = 10'(word); bus_wdata = d;
  endtask

  task automatic wr(int word, logic [31:0] d);
    drive(1, 1, word, d);
  endtask

  task automatic rd(int word, logic [31:0] exp, string req);
    drive(1, 0, word, '0);
    @(negedge clk);
    chk(req, bus_rdata, exp);
  endtask

  task automatic settle_out(logic [31:0] exp, string req);
    drive(0, 0, 0, '0);
    @(negedge clk);
    chk(req, irq_out, exp);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    irq_in = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 outputs in reset", irq_out, '0);
    irq_in = '0;
    @(posedge clk); #2 rst_n = 1;
    @(negedge clk);
    chk("R1 outputs after reset", irq_out, '0);
    rd(0, '0, "R1 status");
    rd(1, '0, "R1 level");
    rd(2, '0, "R1 mask");
    rd(8, '0, "R1 passthrough");

    wr(2, 32'h0000_00F0);
    rd(2, 32'h0000_00F0, "R4 mask set");
    wr(3, 32'h0000_0030);
    rd(2, 32'h0000_00C0, "R4 mask clear");

    wr(4, 32'h0000_0081);
    rd(1, 32'h0000_0081, "R3 level set");
    rd(0, 32'h0000_0080, "R5 masked status");
    chk("R6 cascade high", {31'b0, irq_out[31]}, 32'd1);
    wr(5, 32'h0000_0080);
    rd(1, 32'h0000_0001, "R3 level clear");
    chk("R6 cascade low", {31'b0, irq_out[31]}, 32'd0);

    wr(8, 32'hFFFF_FFFF);
    rd(8, 32'h7FE0_0000, "R7 passthrough set range");
    drive(0, 0, 0, '0);
    irq_in[22] = 1'b1;
    settle_out(32'h0040_0000, "R8 line 22 follows input, mask ignored");
    wr(9, 32'h0040_0000);
    settle_out(32'h0000_0000, "R8 line 22 low when disabled");
    rd(8, 32'h7FA0_0000, "R7 passthrough clear");

    drive(1, 1, 5, 32'h0000_0020);
    irq_in[5] = 1'b1;
    rd(1, 32'h0040_0021, "R2 input change beats clear");
    drive(0, 0, 0, '0);
    irq_in[5] = 1'b0;
    rd(1, 32'h0040_0001, "R2 input falls");

    wr(6, 32'hFFFF_FFFF);
    wr(7, 32'hFFFF_FFFF);
    wr(0, 32'hFFFF_FFFF);
    rd(6, '0, "R9 undefined read");
    rd(2, 32'h0000_00C0, "R9 mask untouched");
    rd(8, 32'h7FA0_0000, "R9 passthrough untouched");
    rd(1, 32'h0040_0001, "R9 level untouched");
    rd(1023, '0, "R9 top index reads zero");

    for (int n = 0; n < 4000; n++) begin
      drive($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
            $urandom_range(0, 11), $urandom());
      irq_in = irq_in ^ ($urandom() & $urandom() & $urandom());
    end
    drive(0, 0, 0, '0);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule